// File: doc/BRIEF.md
# Automatic Test-Pulse Burst Sequencer

This block produces a programmed burst of digital test pulses used to calibrate pixel front-ends without host intervention. Three configuration inputs set the burst: how many pulses to issue, how many clock cycles each pulse stays high, and how many clock cycles the line stays low between two pulses. A one-cycle `start` launches the burst. `busy` is high while pulses are being produced. `done` rises when the last pulse has ended and stays high until the next launch.

The pulse count is 16 bits wide. A burst can therefore hold far more pulses than a 13-bit event counter needs to saturate, since such a counter saturates at 8191 pulses.

A bypass select hands the pulse line to an external trigger pin. While the bypass is active, the internal sequencer is held idle and any burst in progress is abandoned.

Top module: `tpulse_burst_gen`

## Requirements
- R1: After reset, `pulse_out`, `busy` and `done` are all low.
- R2: A launch with `num_pulses` N > 0 produces exactly N rising edges on `pulse_out`. Each pulse is high for H' cycles, where H' = `high_cycles`, or 1 when `high_cycles` is 0.
- R3: Between two consecutive pulses the line is low for G' cycles, where G' = `gap_cycles`, or 1 when `gap_cycles` is 0.
- R4: The first pulse is high in the cycle that follows the clock edge sampling `start`. `done` becomes visible N*H' + (N-1)*G' edges after that sampling edge. `done` then stays high until the next accepted launch or until bypass is selected.
- R5: A launch with N = 0 produces no pulse, and `done` is high right after the sampling edge.
- R6: The count accepts any value up to 65535, including values of 8191 and above, and produces that exact number of pulses.
- R7: The count, high length and gap length are captured at launch. Changing the inputs during a burst does not alter that burst.
- R8: `start` asserted while `busy` is high is ignored: the burst keeps its pulse count and timing.
- R9: While `ext_mode` is 1, `pulse_out` follows `ext_trig` with no clock delay, and `busy` and `done` are low from the next edge on. A burst in progress is abandoned and does not resume when `ext_mode` returns to 0.
- R10: `busy` is high from the edge sampling `start` until the edge ending the last pulse. It is never high at the same time as `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches a burst when the sequencer is idle or done |
| ext_mode | input | 1 | 1 selects the external trigger and holds the sequencer idle |
| ext_trig | input | 1 | External trigger passed to `pulse_out` in bypass |
| num_pulses | input | 16 | Number of pulses in a burst |
| gap_cycles | input | 16 | Low cycles between pulses (0 treated as 1) |
| high_cycles | input | 8 | High cycles per pulse (0 treated as 1) |
| pulse_out | output | 1 | Test-pulse line |
| busy | output | 1 | Burst in progress |
| done | output | 1 | Burst finished |

## Verification
A wrong phase or pulse counter appears on `pulse_out` within one pulse period. It shows up as a pulse that is too wide, a gap that is too short, or an extra or missing pulse. The error then moves the cycle in which `done` rises, so counting edges and the cycles to `done` exposes every counter fault by the end of the burst. A state machine stuck in the wrong state shows at the next edge: `busy` and `done` overlap, `done` drops without a launch, or bypass leaves the sequencer active. The saturating-length burst confirms that the upper bits of the count are really used.

// File: rtl/tpb_pkg.sv
package tpb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HIGH = 2'd1,
    ST_GAP  = 2'd2,
    ST_DONE = 2'd3
  } tpb_state_e;

  // A programmed length of zero is promoted to one cycle.
  function automatic logic [31:0] eff_len(input logic [31:0] v);
    return (v == 32'd0) ? 32'd1 : v;
  endfunction

  // Edges from launch until done is visible.
  function automatic logic [47:0] burst_span(input logic [31:0] n,
                                             input logic [31:0] h,
                                             input logic [31:0] g);
    if (n == 32'd0) return 48'd0;
    return 48'(n) * 48'(eff_len(h)) + (48'(n) - 48'd1) * 48'(eff_len(g));
  endfunction

endpackage

// File: rtl/tpb_counter.sv
module tpb_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] value
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   value <= '0;
    else if (clr) value <= '0;
    else if (inc) value <= value + W'(1);
  end

endmodule

// File: rtl/tpb_fsm.sv
module tpb_fsm
  import tpb_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DLY_W  = 16,
  parameter int HIGH_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ext_mode,
  input  logic [CNT_W-1:0]  num_pulses,
  input  logic [DLY_W-1:0]  gap_cycles,
  input  logic [HIGH_W-1:0] high_cycles,
  output logic              seq_pulse,
  output logic              busy_o,
  output logic              done_o
);

  localparam int PH_W = (DLY_W > HIGH_W) ? DLY_W : HIGH_W;

  tpb_state_e        state_q, state_d;
  logic [CNT_W-1:0]  num_sh;
  logic [PH_W-1:0]   high_sh, gap_sh;
  logic [CNT_W-1:0]  sent_cnt;
  logic [PH_W-1:0]   phase_cnt;

  // Named internal events used by the logic and the assertions.
  logic in_high, in_gap, start_acc, phase_last, last_pulse;
  logic [PH_W-1:0] phase_len;

  assign in_high    = (state_q == ST_HIGH);
  assign in_gap     = (state_q == ST_GAP);
  assign start_acc  = start && !ext_mode &&
                      ((state_q == ST_IDLE) || (state_q == ST_DONE));
  assign phase_len  = in_high ? high_sh : gap_sh;
  assign phase_last = (in_high || in_gap) && (phase_cnt == phase_len - PH_W'(1));
  assign last_pulse = in_high && phase_last && (sent_cnt == num_sh - CNT_W'(1));

  tpb_counter #(.W(PH_W)) u_phase_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start_acc || phase_last || ext_mode),
    .inc   (in_high || in_gap),
    .value (phase_cnt)
  );

  tpb_counter #(.W(CNT_W)) u_sent_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start_acc || ext_mode),
    .inc   (in_high && phase_last),
    .value (sent_cnt)
  );

  always_comb begin
    state_d = state_q;
    if (ext_mode) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: if (start_acc)
                            state_d = (num_pulses == '0) ? ST_DONE : ST_HIGH;
        ST_HIGH:          if (phase_last)
                            state_d = last_pulse ? ST_DONE : ST_GAP;
        ST_GAP:           if (phase_last) state_d = ST_HIGH;
        default:          state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      num_sh  <= '0;
      high_sh <= PH_W'(1);
      gap_sh  <= PH_W'(1);
    end else begin
      state_q <= state_d;
      if (start_acc) begin
        num_sh  <= num_pulses;
        high_sh <= PH_W'(eff_len(32'(high_cycles)));
        gap_sh  <= PH_W'(eff_len(32'(gap_cycles)));
      end
    end
  end

  assign seq_pulse = in_high;
  assign busy_o    = in_high || in_gap;
  assign done_o    = (state_q == ST_DONE);

  // R5
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_acc && num_pulses == '0) |=> (done_o && !seq_pulse));

  // R9
  ext_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mode |=> (!busy_o && !done_o));

  // R4
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start && !ext_mode) |=> done_o);

  // R2
  sent_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (sent_cnt < num_sh));

  // R3
  gap_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_gap |-> (phase_cnt < gap_sh));

  // R7
  cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> ($stable(num_sh) && $stable(high_sh) && $stable(gap_sh)));

  // R10
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));

endmodule

// File: rtl/tpb_out_mux.sv
module tpb_out_mux (
  input  logic ext_mode,
  input  logic ext_trig,
  input  logic seq_pulse,
  output logic pulse_out
);

  assign pulse_out = ext_mode ? ext_trig : seq_pulse;

endmodule

// File: rtl/tpulse_burst_gen.sv
module tpulse_burst_gen #(
  parameter int CNT_W  = 16,
  parameter int DLY_W  = 16,
  parameter int HIGH_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ext_mode,
  input  logic              ext_trig,
  input  logic [CNT_W-1:0]  num_pulses,
  input  logic [DLY_W-1:0]  gap_cycles,
  input  logic [HIGH_W-1:0] high_cycles,
  output logic              pulse_out,
  output logic              busy,
  output logic              done
);

  logic seq_pulse;

  tpb_fsm #(.CNT_W(CNT_W), .DLY_W(DLY_W), .HIGH_W(HIGH_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .ext_mode    (ext_mode),
    .num_pulses  (num_pulses),
    .gap_cycles  (gap_cycles),
    .high_cycles (high_cycles),
    .seq_pulse   (seq_pulse),
    .busy_o      (busy),
    .done_o      (done)
  );

  tpb_out_mux u_mux (
    .ext_mode  (ext_mode),
    .ext_trig  (ext_trig),
    .seq_pulse (seq_pulse),
    .pulse_out (pulse_out)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (!busy && !done));

endmodule

// File: tb/tpulse_burst_gen_tb.sv
module tpulse_burst_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        ext_mode = 1'b0;
  logic        ext_trig = 1'b0;
  logic [15:0] num_pulses = '0;
  logic [15:0] gap_cycles = '0;
  logic [7:0]  high_cycles = '0;
  logic        pulse_out, busy, done;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  tpulse_burst_gen u_dut (
    .clk (clk), .rst_n (rst_n), .start (start), .ext_mode (ext_mode),
    .ext_trig (ext_trig), .num_pulses (num_pulses), .gap_cycles (gap_cycles),
    .high_cycles (high_cycles), .pulse_out (pulse_out), .busy (busy), .done (done)
  );

  // {count, high, gap}
  localparam logic [47:0] VEC [0:5] = '{
    {16'd1, 16'd1, 16'd1},
    {16'd3, 16'd2, 16'd4},
    {16'd5, 16'd1, 16'd0},
    {16'd2, 16'd0, 16'd3},
    {16'd4, 16'd3, 16'd1},
    {16'd0, 16'd5, 16'd5}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint xlen(input longint v);
    return (v == 0) ? 1 : v;
  endfunction

  // Launch at a negedge, then observe until done. perturb alters cfg and re-pulses start mid-burst.
  task automatic run_burst(input int n, input int h, input int g, input bit perturb,
                           output longint pulses, output longint hi, output longint lat,
                           output longint busy_done_overlap);
    bit prev;
    longint cyc;
    num_pulses  = 16'(n);
    high_cycles = 8'(h);
    gap_cycles  = 16'(g);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 0; pulses = 0; hi = 0; prev = 1'b0; busy_done_overlap = 0;
    while (!done && cyc < 100000) begin
      if (pulse_out) hi++;
      if (pulse_out && !prev) pulses++;
      if (busy && done) busy_done_overlap++;
      prev = pulse_out;
      if (perturb && cyc == 1) begin
        num_pulses = 16'd9; high_cycles = 8'd5; gap_cycles = 16'd5; start = 1'b1;
      end
      if (cyc == 2) start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    if (pulse_out && !prev) pulses++;
    lat = cyc;
  endtask

  initial begin
    #(150000 * 5);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    longint p, hi, lat, ov;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!pulse_out && !busy && !done, "R1 reset outputs", {pulse_out, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!pulse_out && !busy && !done, "R1 after release", {pulse_out, busy, done}, 0);

    // Vector table: R2 R3 R4 R5 R10
    for (int i = 0; i < 6; i++) begin
      int n, h, g;
      longint eh, eg, elat;
      n = int'(VEC[i][47:32]); h = int'(VEC[i][31:16]); g = int'(VEC[i][15:0]);
      eh = xlen(h); eg = xlen(g);
      elat = (n == 0) ? 0 : n * eh + (n - 1) * eg;
      run_burst(n, h, g, 1'b0, p, hi, lat, ov);
      chk(p == n, (n == 0) ? "R5 zero count pulses" : "R2 pulse count", p, n);
      chk(hi == n * eh, "R2 high cycles total", hi, n * eh);
      chk(lat == elat, (n == 0) ? "R5 done latency" : "R3 R4 done latency", lat, elat);
      chk(ov == 0, "R10 busy with done", ov, 0);
    end

    // R4 done holds
    repeat (5) @(negedge clk);
    chk(done && !busy, "R4 done held", done, 1);

    // R7 R8 config change and start during burst
    run_burst(3, 2, 2, 1'b1, p, hi, lat, ov);
    chk(p == 3, "R7 R8 pulse count unchanged", p, 3);
    chk(lat == 10, "R7 R8 latency unchanged", lat, 10);
    chk(hi == 6, "R7 high total unchanged", hi, 6);

    // R6 saturating count
    run_burst(8200, 1, 1, 1'b0, p, hi, lat, ov);
    chk(p == 8200, "R6 large count pulses", p, 8200);
    chk(lat == 16399, "R6 large count latency", lat, 16399);

    // R9 bypass pass-through
    ext_mode = 1'b1; ext_trig = 1'b1;
    #1;
    chk(pulse_out == 1'b1, "R9 trig high passes", pulse_out, 1);
    ext_trig = 1'b0;
    #1;
    chk(pulse_out == 1'b0, "R9 trig low passes", pulse_out, 0);
    @(negedge clk);
    chk(!done && !busy, "R9 done cleared", {busy, done}, 0);
    ext_mode = 1'b0;

    // R9 abort mid-burst and no resume
    num_pulses = 16'd10; high_cycles = 8'd2; gap_cycles = 16'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy, "R10 busy during burst", busy, 1);
    ext_mode = 1'b1; ext_trig = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !pulse_out, "R9 abort idles", {pulse_out, busy, done}, 0);
    ext_mode = 1'b0;
    p = 0;
    for (int k = 0; k < 30; k++) begin
      if (pulse_out) p++;
      @(negedge clk);
    end
    chk(p == 0 && !done && !busy, "R9 no resume", p, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule